// File: doc/BRIEF.md
# Parallel Pattern Block Compressor and Decompressor

This block shrinks a 64-byte memory block by trying six encodings at the same time and keeping the one with the fewest bytes. The compressor takes a block through a valid/ready input. It returns a 3-bit pattern code, a byte count and a payload. The payload is packed from bit 0 upward, and every bit above the byte count is zero. A memory controller would store the code and the payload, then later hand both to the decompressor.

The decompressor turns the code into one-hot unit enables. Only the enabled unit rebuilds the raw block, and the same enable selects that unit's result at the output multiplexer. Codes that name no pattern raise an error flag. The encodings are: an all-zero block, one repeated 8-byte word, and three base-plus-delta forms. The last pattern is a raw fallback that always applies.

Top module: `bdx_codec`

## Requirements
- R1: While reset is asserted, `cmp_ready`, `cmp_out_valid` and `dcp_out_valid` are 0. From the first clock edge after reset is released, `cmp_ready` is 1.
- R2: A block accepted on a clock edge (`cmp_valid` and `cmp_ready` both 1) appears on the compressor outputs with `cmp_out_valid` = 1 exactly two edges later. A new block can be accepted on every edge.
- R3: The pattern codes and payload sizes are: 0 = all-zero (0 bytes); 1 = repeated word (8 bytes, holding word 0); 2 = 8-byte base with 1-byte deltas (16 bytes); 3 = 8-byte base with 2-byte deltas (24 bytes); 4 = 4-byte base with 1-byte deltas (20 bytes); 5 = raw (64 bytes, the block itself). A block is split into little-endian words, where word i occupies bytes i*W to i*W+W-1. For the delta forms, the base is word 0 and occupies the lowest payload bytes. Delta i follows at byte W + i*D.
- R4: Delta i is word i minus word 0, taken modulo 2^(8*W). A delta form applies only if every such difference, read as a signed value, fits in D bytes.
- R5: The compressor reports the applicable pattern with the smallest size. When two patterns have the same size, the lower code wins.
- R6: Every payload bit at or above bit 8*`cmp_out_len` is 0.
- R7: One edge after `dcp_valid`, `dcp_out_valid` is 1. For codes 0 to 5, `dcp_out_block` then equals the block that produced that code and payload, and `dcp_out_err` is 0.
- R8: For codes 6 and 7, the decompressor sets `dcp_out_err` to 1 and returns an all-zero block.
- R9: On an edge where `dcp_valid` is 0, `dcp_out_valid` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Raw block offered to the compressor |
| cmp_ready | output | 1 | Compressor can accept a block |
| cmp_block | input | 512 | Raw block, byte 0 in bits 7:0 |
| cmp_out_valid | output | 1 | Compressed result present |
| cmp_out_id | output | 3 | Chosen pattern code |
| cmp_out_len | output | 7 | Payload size in bytes |
| cmp_out_payload | output | 512 | Packed payload, zero above the size |
| dcp_valid | input | 1 | Code and payload offered to the decompressor |
| dcp_id | input | 3 | Pattern code to decode |
| dcp_payload | input | 512 | Payload to expand |
| dcp_out_valid | output | 1 | Restored block present |
| dcp_out_block | output | 512 | Restored raw block |
| dcp_out_err | output | 1 | Code named no pattern |

## Verification
A wrong sign test in a delta unit shows up at the ports in one of two ways. The compressor may report a code that is larger than needed two cycles after the block is accepted. Or the decompressor may rebuild a block that differs from the original one cycle after the payload comes back. Each block is therefore sent through both halves, and the code, size and payload are compared with values the bench computes itself. A mistake in the selector's ordering changes the reported code on blocks that fit several patterns. Missing payload clearing shows up as non-zero bits above the reported size. Boundary deltas (127, -128, 128, 32767, -32768) and a word-0 value that wraps around are each sent as directed blocks.

// File: rtl/bdx_pkg.sv
package bdx_pkg;
  localparam int BLK_BYTES_DEF = 64;
  localparam int NPAT = 6;
  localparam int ID_W = 3;

  typedef enum logic [ID_W-1:0] {
    PAT_ZERO = 3'd0,
    PAT_REP8 = 3'd1,
    PAT_B8D1 = 3'd2,
    PAT_B8D2 = 3'd3,
    PAT_B4D1 = 3'd4,
    PAT_RAW  = 3'd5
  } pat_e;

  // payload bytes for a base-plus-delta form
  function automatic int bd_size(input int base_b, input int delta_b, input int blk_b);
    return base_b + (blk_b / base_b) * delta_b;
  endfunction
endpackage

// File: rtl/bdx_bd_enc.sv
module bdx_bd_enc #(
  parameter int BLK_BYTES   = 64,
  parameter int BASE_BYTES  = 8,
  parameter int DELTA_BYTES = 1
) (
  input  logic [BLK_BYTES*8-1:0] blk,
  output logic                   fits,
  output logic [BLK_BYTES*8-1:0] payload
);
  localparam int NW = BLK_BYTES / BASE_BYTES;
  localparam int WB = BASE_BYTES * 8;
  localparam int DB = DELTA_BYTES * 8;
  localparam int BB = BLK_BYTES * 8;

  logic [NW-1:0]    lane_ok;
  logic [NW*DB-1:0] dpack;

  for (genvar i = 0; i < NW; i++) begin : g_lane
    logic [WB-1:0] diff;
    logic [WB-DB:0] hi;
    assign diff = blk[i*WB +: WB] - blk[WB-1:0];
    assign hi   = diff[WB-1:DB-1];
    // signed fit: upper bits all copies of the delta sign
    assign lane_ok[i] = (&hi) | ~(|hi);
    assign dpack[i*DB +: DB] = diff[DB-1:0];
  end

  assign fits    = &lane_ok;
  assign payload = BB'({dpack, blk[WB-1:0]});
endmodule

// File: rtl/bdx_bd_dec.sv
module bdx_bd_dec #(
  parameter int BLK_BYTES   = 64,
  parameter int BASE_BYTES  = 8,
  parameter int DELTA_BYTES = 1
) (
  input  logic [BLK_BYTES*8-1:0] payload,
  output logic [BLK_BYTES*8-1:0] blk
);
  localparam int NW = BLK_BYTES / BASE_BYTES;
  localparam int WB = BASE_BYTES * 8;
  localparam int DB = DELTA_BYTES * 8;

  for (genvar i = 0; i < NW; i++) begin : g_lane
    logic [DB-1:0] d;
    assign d = payload[WB + i*DB +: DB];
    assign blk[i*WB +: WB] = payload[WB-1:0] + {{(WB-DB){d[DB-1]}}, d};
  end
endmodule

// File: rtl/bdx_compress.sv
module bdx_compress
  import bdx_pkg::*;
#(
  parameter int BLK_BYTES = BLK_BYTES_DEF,
  parameter int LEN_W     = $clog2(BLK_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [BLK_BYTES*8-1:0] in_blk,
  output logic                   out_valid,
  output logic [ID_W-1:0]        out_id,
  output logic [LEN_W-1:0]       out_len,
  output logic [BLK_BYTES*8-1:0] out_payload
);
  localparam int BB   = BLK_BYTES * 8;
  localparam int NREP = BLK_BYTES / 8;

  // ---------------- stage 1: capture ----------------
  logic          ready_q, ready_d;
  logic          s1_vld_q, s1_vld_d;
  logic [BB-1:0] s1_blk_q, s1_blk_d;
  logic          accept;

  assign accept   = in_valid & ready_q;
  assign in_ready = ready_q;

  always_comb begin
    ready_d  = 1'b1;
    s1_vld_d = accept;
    s1_blk_d = accept ? in_blk : s1_blk_q;
  end

  // ---------------- pattern units ----------------
  logic [NPAT-1:0] cand_ok;
  logic [BB-1:0]   cand_pl  [NPAT];
  logic [LEN_W-1:0] cand_len [NPAT];
  logic [NREP-1:0] rep_eq;

  for (genvar i = 0; i < NREP; i++) begin : g_rep
    assign rep_eq[i] = (s1_blk_q[i*64 +: 64] == s1_blk_q[63:0]);
  end

  assign cand_ok[PAT_ZERO]  = ~(|s1_blk_q);
  assign cand_pl[PAT_ZERO]  = '0;
  assign cand_len[PAT_ZERO] = '0;

  assign cand_ok[PAT_REP8]  = &rep_eq;
  assign cand_pl[PAT_REP8]  = BB'(s1_blk_q[63:0]);
  assign cand_len[PAT_REP8] = LEN_W'(8);

  bdx_bd_enc #(.BLK_BYTES(BLK_BYTES), .BASE_BYTES(8), .DELTA_BYTES(1)) u_b8d1 (
    .blk(s1_blk_q), .fits(cand_ok[PAT_B8D1]), .payload(cand_pl[PAT_B8D1]));
  assign cand_len[PAT_B8D1] = LEN_W'(bd_size(8, 1, BLK_BYTES));

  bdx_bd_enc #(.BLK_BYTES(BLK_BYTES), .BASE_BYTES(8), .DELTA_BYTES(2)) u_b8d2 (
    .blk(s1_blk_q), .fits(cand_ok[PAT_B8D2]), .payload(cand_pl[PAT_B8D2]));
  assign cand_len[PAT_B8D2] = LEN_W'(bd_size(8, 2, BLK_BYTES));

  bdx_bd_enc #(.BLK_BYTES(BLK_BYTES), .BASE_BYTES(4), .DELTA_BYTES(1)) u_b4d1 (
    .blk(s1_blk_q), .fits(cand_ok[PAT_B4D1]), .payload(cand_pl[PAT_B4D1]));
  assign cand_len[PAT_B4D1] = LEN_W'(bd_size(4, 1, BLK_BYTES));

  assign cand_ok[PAT_RAW]  = 1'b1;
  assign cand_pl[PAT_RAW]  = s1_blk_q;
  assign cand_len[PAT_RAW] = LEN_W'(BLK_BYTES);

  // ---------------- selector ----------------
  logic [LEN_W:0]   best_len;
  logic [ID_W-1:0]  best_id;
  logic [BB-1:0]    best_pl;

  always_comb begin
    best_len = '1;
    best_id  = PAT_RAW;
    best_pl  = s1_blk_q;
    // ascending scan with strict compare keeps the lower code on ties
    for (int k = 0; k < NPAT; k++) begin
      if (cand_ok[k] && ({1'b0, cand_len[k]} < best_len)) begin
        best_len = {1'b0, cand_len[k]};
        best_id  = ID_W'(k);
        best_pl  = cand_pl[k];
      end
    end
  end

  // ---------------- stage 2: result ----------------
  logic             out_vld_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [BB-1:0]    pl_q, pl_d;

  always_comb begin
    out_vld_d = s1_vld_q;
    id_d      = s1_vld_q ? best_id : id_q;
    len_d     = s1_vld_q ? best_len[LEN_W-1:0] : len_q;
    pl_d      = s1_vld_q ? best_pl : pl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      s1_vld_q  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      ready_q   <= ready_d;
      s1_vld_q  <= s1_vld_d;
      out_valid <= out_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    s1_blk_q <= s1_blk_d;
    id_q     <= id_d;
    len_q    <= len_d;
    pl_q     <= pl_d;
  end

  assign out_id      = id_q;
  assign out_len     = len_q;
  assign out_payload = pl_q;

  // ---------------- assertions ----------------
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##2 out_valid);

  assert_id_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_id <= PAT_RAW));

  assert_raw_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_id == PAT_RAW) |-> (out_len == LEN_W'(BLK_BYTES)));

  assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_payload >> {out_len, 3'b000}) == '0));

  assert_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld_q && cand_ok[PAT_ZERO]) |=> (out_id == PAT_ZERO));
endmodule

// File: rtl/bdx_decompress.sv
module bdx_decompress
  import bdx_pkg::*;
#(
  parameter int BLK_BYTES = BLK_BYTES_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [ID_W-1:0]        in_id,
  input  logic [BLK_BYTES*8-1:0] in_pl,
  output logic                   out_valid,
  output logic [BLK_BYTES*8-1:0] out_blk,
  output logic                   out_err
);
  localparam int BB   = BLK_BYTES * 8;
  localparam int NREP = BLK_BYTES / 8;

  // code -> one-hot unit enables
  logic [NPAT-1:0] en;
  logic            bad_id;

  always_comb begin
    en = '0;
    if (in_id < ID_W'(NPAT)) en[in_id] = 1'b1;
  end
  assign bad_id = ~(|en);

  logic [BB-1:0] unit_blk [NPAT];

  assign unit_blk[PAT_ZERO] = '0;
  assign unit_blk[PAT_REP8] = {NREP{in_pl[63:0]}};

  bdx_bd_dec #(.BLK_BYTES(BLK_BYTES), .BASE_BYTES(8), .DELTA_BYTES(1)) u_b8d1 (
    .payload(in_pl), .blk(unit_blk[PAT_B8D1]));
  bdx_bd_dec #(.BLK_BYTES(BLK_BYTES), .BASE_BYTES(8), .DELTA_BYTES(2)) u_b8d2 (
    .payload(in_pl), .blk(unit_blk[PAT_B8D2]));
  bdx_bd_dec #(.BLK_BYTES(BLK_BYTES), .BASE_BYTES(4), .DELTA_BYTES(1)) u_b4d1 (
    .payload(in_pl), .blk(unit_blk[PAT_B4D1]));

  assign unit_blk[PAT_RAW] = in_pl;

  // enable-steered AND-OR output mux
  logic [BB-1:0] mux_blk;
  always_comb begin
    mux_blk = '0;
    for (int k = 0; k < NPAT; k++) begin
      mux_blk = mux_blk | (unit_blk[k] & {BB{en[k]}});
    end
  end

  logic          vld_d, err_q, err_d;
  logic [BB-1:0] blk_q, blk_d;

  always_comb begin
    vld_d = in_valid;
    blk_d = in_valid ? mux_blk : blk_q;
    err_d = in_valid ? bad_id : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld_d;
  end

  always_ff @(posedge clk) begin
    blk_q <= blk_d;
    err_q <= err_d;
  end

  assign out_blk = blk_q;
  assign out_err = err_q;

  // ---------------- assertions ----------------
  assert_onehot_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_bad_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_id >= ID_W'(NPAT)) |=> (out_err && out_blk == '0));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

// File: rtl/bdx_codec.sv
module bdx_codec
  import bdx_pkg::*;
#(
  parameter int BLK_BYTES = BLK_BYTES_DEF,
  parameter int LEN_W     = $clog2(BLK_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmp_valid,
  output logic                   cmp_ready,
  input  logic [BLK_BYTES*8-1:0] cmp_block,
  output logic                   cmp_out_valid,
  output logic [ID_W-1:0]        cmp_out_id,
  output logic [LEN_W-1:0]       cmp_out_len,
  output logic [BLK_BYTES*8-1:0] cmp_out_payload,
  input  logic                   dcp_valid,
  input  logic [ID_W-1:0]        dcp_id,
  input  logic [BLK_BYTES*8-1:0] dcp_payload,
  output logic                   dcp_out_valid,
  output logic [BLK_BYTES*8-1:0] dcp_out_block,
  output logic                   dcp_out_err
);
  bdx_compress #(.BLK_BYTES(BLK_BYTES), .LEN_W(LEN_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cmp_valid), .in_ready(cmp_ready), .in_blk(cmp_block),
    .out_valid(cmp_out_valid), .out_id(cmp_out_id),
    .out_len(cmp_out_len), .out_payload(cmp_out_payload));

  bdx_decompress #(.BLK_BYTES(BLK_BYTES)) u_dcp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dcp_valid), .in_id(dcp_id), .in_pl(dcp_payload),
    .out_valid(dcp_out_valid), .out_blk(dcp_out_block), .out_err(dcp_out_err));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_ready) |-> (!cmp_out_valid && !dcp_out_valid));
endmodule

// File: tb/bdx_codec_test.sv
module bdx_codec_test;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmp_valid;
  logic         cmp_ready;
  logic [511:0] cmp_block;
  logic         cmp_out_valid;
  logic [2:0]   cmp_out_id;
  logic [6:0]   cmp_out_len;
  logic [511:0] cmp_out_payload;
  logic         dcp_valid;
  logic [2:0]   dcp_id;
  logic [511:0] dcp_payload;
  logic         dcp_out_valid;
  logic [511:0] dcp_out_block;
  logic         dcp_out_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  bdx_codec uut (
    .clk(clk), .rst_n(rst_n),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_block(cmp_block),
    .cmp_out_valid(cmp_out_valid), .cmp_out_id(cmp_out_id),
    .cmp_out_len(cmp_out_len), .cmp_out_payload(cmp_out_payload),
    .dcp_valid(dcp_valid), .dcp_id(dcp_id), .dcp_payload(dcp_payload),
    .dcp_out_valid(dcp_out_valid), .dcp_out_block(dcp_out_block),
    .dcp_out_err(dcp_out_err));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [63:0] word_of(input logic [511:0] b, input int wb, input int i);
    logic [63:0] w = '0;
    for (int k = 0; k < wb; k++) w[k*8 +: 8] = b[(i*wb + k)*8 +: 8];
    return w;
  endfunction

  function automatic logic [63:0] mask_of(input int nbytes);
    if (nbytes >= 8) return '1;
    return (64'd1 << (nbytes*8)) - 64'd1;
  endfunction

  function automatic bit bd_fits(input logic [511:0] b, input int wb, input int db);
    logic [63:0] wm = mask_of(wb);
    logic [63:0] dm = mask_of(db);
    logic [63:0] base = word_of(b, wb, 0);
    for (int i = 0; i < 64/wb; i++) begin
      logic [63:0] diff = (word_of(b, wb, i) - base) & wm;
      logic [63:0] lo   = diff & dm;
      logic [63:0] sx   = diff[db*8-1] ? (lo | (wm & ~dm)) : lo;
      if (sx != diff) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [511:0] bd_pack(input logic [511:0] b, input int wb, input int db);
    logic [511:0] p = '0;
    logic [63:0] base = word_of(b, wb, 0);
    int pos = 0;
    for (int k = 0; k < wb; k++) begin p[pos*8 +: 8] = base[k*8 +: 8]; pos++; end
    for (int i = 0; i < 64/wb; i++) begin
      logic [63:0] diff = word_of(b, wb, i) - base;
      for (int k = 0; k < db; k++) begin p[pos*8 +: 8] = diff[k*8 +: 8]; pos++; end
    end
    return p;
  endfunction

  task automatic ref_compress(input logic [511:0] b, output int id, output int len,
                              output logic [511:0] pl);
    bit rep = 1'b1;
    int  best = 1000;
    for (int i = 1; i < 8; i++) if (word_of(b, 8, i) != word_of(b, 8, 0)) rep = 1'b0;
    id = 5; len = 64; pl = b;
    if (b == '0 && 0 < best) begin best = 0; id = 0; len = 0; pl = '0; end
    if (rep && 8 < best) begin best = 8; id = 1; len = 8; pl = 512'(word_of(b, 8, 0)); end
    if (bd_fits(b, 8, 1) && 16 < best) begin best = 16; id = 2; len = 16; pl = bd_pack(b, 8, 1); end
    if (bd_fits(b, 8, 2) && 24 < best) begin best = 24; id = 3; len = 24; pl = bd_pack(b, 8, 2); end
    if (bd_fits(b, 4, 1) && 20 < best) begin best = 20; id = 4; len = 20; pl = bd_pack(b, 4, 1); end
  endtask

  // ---------------- stimulus ----------------
  function automatic logic [511:0] gen_block(input int kind);
    logic [511:0] b = '0;
    logic [63:0] base = {$urandom, $urandom};
    case (kind)
      0: b = '0;
      1: for (int i = 0; i < 8; i++) b[i*64 +: 64] = base;
      2: for (int i = 0; i < 8; i++) begin
           logic signed [7:0] d = 8'($urandom);
           b[i*64 +: 64] = base + 64'(longint'(d));
         end
      3: for (int i = 0; i < 8; i++) begin
           logic signed [15:0] d = 16'($urandom);
           b[i*64 +: 64] = base + 64'(longint'(d));
         end
      4: for (int i = 0; i < 16; i++) begin
           logic signed [7:0] d = 8'($urandom);
           b[i*32 +: 32] = base[31:0] + 32'(int'(d));
         end
      default: for (int i = 0; i < 16; i++) b[i*32 +: 32] = $urandom;
    endcase
    return b;
  endfunction

  // one round trip; entered and left at a falling edge
  task automatic run_block(input logic [511:0] b, input string tag, input int want_id);
    int id, len;
    logic [511:0] pl;
    ref_compress(b, id, len, pl);
    cmp_valid = 1'b1; cmp_block = b;
    @(posedge clk); @(negedge clk);
    cmp_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check(cmp_out_valid == 1'b1, "R2", {tag, " out_valid"}, 512'(cmp_out_valid), 512'(1));
    check(cmp_out_id == 3'(id), "R5", {tag, " id"}, 512'(cmp_out_id), 512'(id));
    if (want_id >= 0)
      check(cmp_out_id == 3'(want_id), "R4", {tag, " directed id"}, 512'(cmp_out_id), 512'(want_id));
    check(cmp_out_len == 7'(len), "R3", {tag, " len"}, 512'(cmp_out_len), 512'(len));
    check(cmp_out_payload == pl, "R6", {tag, " payload"}, cmp_out_payload, pl);
    dcp_valid = 1'b1; dcp_id = cmp_out_id; dcp_payload = cmp_out_payload;
    @(posedge clk); @(negedge clk);
    dcp_valid = 1'b0;
    check(dcp_out_valid && !dcp_out_err, "R7", {tag, " dcp valid/err"},
          512'({dcp_out_valid, dcp_out_err}), 512'(2'b10));
    check(dcp_out_block == b, "R7", {tag, " round trip"}, dcp_out_block, b);
  endtask

  function automatic logic [511:0] delta_block(input logic [63:0] base, input longint d);
    logic [511:0] b;
    for (int i = 0; i < 8; i++) b[i*64 +: 64] = base;
    b[3*64 +: 64] = base + 64'(d);
    return b;
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_fail++; n_tests++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] a, b2;
    int ida, la, idb, lb;
    logic [511:0] pa, pb;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmp_valid = 1'b0; cmp_block = '0;
    dcp_valid = 1'b0; dcp_id = '0; dcp_payload = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet during reset
    check(!cmp_ready && !cmp_out_valid && !dcp_out_valid, "R1", "reset outputs",
          512'({cmp_ready, cmp_out_valid, dcp_out_valid}), 512'(0));
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(cmp_ready == 1'b1, "R1", "ready after reset", 512'(cmp_ready), 512'(1));

    // directed corners
    run_block('0, "zero", 0);
    run_block({8{64'hDEAD_BEEF_0123_4567}}, "repeat", 1);
    run_block(delta_block(64'h1000, 127), "d=+127 R4", 2);
    run_block(delta_block(64'h1000, -128), "d=-128 R4", 2);
    run_block(delta_block(64'h1000, 128), "d=+128 R4", 3);
    run_block(delta_block(64'h1000, 32767), "d=+32767 R4", 3);
    run_block(delta_block(64'h1000, -32768), "d=-32768 R4", 3);
    run_block(delta_block(64'h0, 32768), "d=+32768 R4", 5);
    b2 = '0; b2[63:0] = '1;
    run_block(b2, "wrap R4", 2);
    for (int i = 0; i < 16; i++) b2[i*32 +: 32] = 32'h7000_0000 + 32'(i);
    run_block(b2, "lanes32 R5", 4);

    // random mix
    for (int n = 0; n < 150; n++) run_block(gen_block(n % 6), "random", -1);

    // R2: back-to-back acceptance
    a  = gen_block(2);
    b2 = gen_block(4);
    ref_compress(a, ida, la, pa);
    ref_compress(b2, idb, lb, pb);
    cmp_valid = 1'b1; cmp_block = a;
    @(posedge clk); @(negedge clk);
    cmp_block = b2;
    @(posedge clk); @(negedge clk);
    cmp_valid = 1'b0;
    check(cmp_out_valid && cmp_out_payload == pa && cmp_out_id == 3'(ida), "R2",
          "back-to-back first", cmp_out_payload, pa);
    @(posedge clk); @(negedge clk);
    check(cmp_out_valid && cmp_out_payload == pb && cmp_out_id == 3'(idb), "R2",
          "back-to-back second", cmp_out_payload, pb);
    @(posedge clk); @(negedge clk);
    check(cmp_out_valid == 1'b0, "R2", "valid drops", 512'(cmp_out_valid), 512'(0));

    // R8: unused codes
    for (int c = 6; c < 8; c++) begin
      dcp_valid = 1'b1; dcp_id = 3'(c); dcp_payload = {16{32'hA5A5_5A5A}};
      @(posedge clk); @(negedge clk);
      dcp_valid = 1'b0;
      check(dcp_out_valid && dcp_out_err, "R8", "bad code flagged",
            512'({dcp_out_valid, dcp_out_err}), 512'(2'b11));
      check(dcp_out_block == '0, "R8", "bad code block", dcp_out_block, '0);
      @(posedge clk); @(negedge clk);
      check(dcp_out_valid == 1'b0, "R9", "idle clears valid", 512'(dcp_out_valid), 512'(0));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule